// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block decides which of three system power states is in force (run, sleep, off) and turns that decision into enable lines for four regulator rails. A switching rail that feeds memory runs in both run and sleep; in sleep it is told to switch at its higher standby frequency. A termination rail and a pair of linear rails run only in the run state, and only once the switching rail has finished its soft start and reports that it is in regulation.

The sleep request and the three supply-good flags come from asynchronous monitors, so each passes through a two-flop synchronizer before it is decoded. The main-supply flags count as good only while the standby supply is good. Sleep and off never pass directly into each other. An over-temperature flag latches a thermal trip that forces the off state from any state. The trip clears only when the separate under-temperature flag reports that the die has cooled past the lower threshold. The analog monitors and the temperature sensing lie outside the block and arrive as flag bits.

Top module: `acpi_pwr_seq`

## Requirements
- R1: After reset the state output reads off (2'b10), where the codes are run = 2'b00, sleep = 2'b01 and off = 2'b10, and all four rail enables are low.
- R2: From off, with the sleep request low, the standby flag high and both main-supply flags high, the state becomes run on the third rising edge after the inputs change, and not before.
- R3: From run, a high sleep request moves the state to sleep. In sleep the switching-rail enable and the standby-frequency select are high, and the termination and linear enables are low.
- R4: From sleep, the state returns to run only when the sleep request is low and both main-supply flags are high. With the sleep request low and a main supply missing, the state stays sleep.
- R5: From run, a low sleep request with either main-supply flag low moves the state to off, and every enable drops.
- R6: Off never moves to sleep and sleep never moves to off, except when sleep moves to off through a thermal trip. In particular, off with a high sleep request stays off.
- R7: While the standby flag is low, the main-supply flags are treated as bad, so off does not move to run.
- R8: In run, the switching-rail enable is high and the standby-frequency select is low. The termination and linear enables are high only while both the soft-start-done flag and the in-regulation flag are high.
- R9: A high over-temperature flag forces the off state by the second rising edge, from run or from sleep, and holds it there.
- R10: The thermal trip clears only when the under-temperature flag is high and the over-temperature flag is low. While the trip is set the state stays off; after it clears, the normal rules for leaving off apply.
- R11: When a thermal trip and a sleep request reach the state decode in the same cycle, the trip wins and the state goes from run straight to off without passing through sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_good_i | input | 1 | Standby supply good (asynchronous) |
| main_a_good_i | input | 1 | First main supply good (asynchronous) |
| main_b_good_i | input | 1 | Second main supply good (asynchronous) |
| sleep_req_i | input | 1 | Sleep request, high asks for the sleep state (asynchronous) |
| temp_over_i | input | 1 | Die above the upper thermal threshold |
| temp_under_i | input | 1 | Die below the lower thermal threshold |
| sw_inreg_i | input | 1 | Switching rail in regulation |
| sw_ss_done_i | input | 1 | Switching rail soft start complete |
| state_o | output | 2 | Power state code (00 run, 01 sleep, 10 off) |
| sw_en_o | output | 1 | Switching rail enable |
| stby_freq_o | output | 1 | Switching rail standby (doubled) frequency select |
| term_en_o | output | 1 | Termination rail enable |
| lin_en_o | output | 1 | Linear rail pair enable |

## Verification
A thermal trip and a sleep request can both reach the state decode in the same cycle. The bench raises the sleep request in run and then raises the over-temperature flag one cycle later. The synchronizer is one flop deeper than the thermal latch, so both events reach the decode on the same edge. The bench samples the state on every following cycle: a single sleep code counts as a failure, and the run must end in off. The same trip is also applied while the block is already in sleep, to confirm that the thermal exit is the only path from sleep to off.

// File: rtl/acpi_pwr_seq_pkg.sv
package acpi_pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'b00,
        PS_SLEEP = 2'b01,
        PS_OFF   = 2'b10
    } pwr_state_e;

    typedef struct packed {
        logic stby_good;
        logic main_a_good;
        logic main_b_good;
        logic sleep_req;
    } supply_flags_t;

    localparam int unsigned FLAG_W = $bits(supply_flags_t);

    typedef struct packed {
        logic sw_en;
        logic stby_freq;
        logic term_en;
        logic lin_en;
    } rail_ctrl_t;

    // Both main supplies count only once the standby supply is good.
    function automatic logic mains_ok(input supply_flags_t f);
        return f.stby_good & f.main_a_good & f.main_b_good;
    endfunction

    // Transition decode. A thermal trip takes priority over every other rule.
    function automatic pwr_state_e pwr_next(input pwr_state_e cur,
                                            input supply_flags_t f,
                                            input logic hot);
        pwr_state_e nxt;
        nxt = cur;
        if (hot) begin
            nxt = PS_OFF;
        end else begin
            case (cur)
                PS_OFF:   if (!f.sleep_req && mains_ok(f)) nxt = PS_RUN;
                PS_RUN: begin
                    if (f.sleep_req)          nxt = PS_SLEEP;
                    else if (!mains_ok(f))    nxt = PS_OFF;
                end
                PS_SLEEP: if (!f.sleep_req && mains_ok(f)) nxt = PS_RUN;
                default:  nxt = PS_OFF;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/acpi_pwr_seq_sync.sv
module acpi_pwr_seq_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/acpi_pwr_seq_thermal.sv
module acpi_pwr_seq_thermal (
    input  logic clk,
    input  logic rst,
    input  logic over_i,
    input  logic under_i,
    output logic hot_o
);
    logic hot_q;

    always_ff @(posedge clk) begin
        if (rst)          hot_q <= 1'b0;
        else if (over_i)  hot_q <= 1'b1;
        else if (under_i) hot_q <= 1'b0;
    end

    assign hot_o = hot_q;

    // R9: an over-temperature flag sets the trip on the next edge
    a_r9_trip_sets: assert property (@(posedge clk) disable iff (rst)
        over_i |=> hot_q);
    // R10: the trip holds until the die reports it has cooled
    a_r10_trip_holds: assert property (@(posedge clk) disable iff (rst)
        (hot_q && !under_i) |=> hot_q);
endmodule

// File: rtl/acpi_pwr_seq_fsm.sv
module acpi_pwr_seq_fsm
    import acpi_pwr_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  supply_flags_t flags_i,
    input  logic          hot_i,
    output pwr_state_e    state_o
);
    pwr_state_e state_q;
    pwr_state_e state_d;

    always_comb state_d = pwr_next(state_q, flags_i, hot_i);

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_OFF;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

    // R6: off never goes to sleep
    a_r6_off_not_sleep: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_OFF) |=> (state_q != PS_SLEEP));
    // R6: sleep leaves for off only through a thermal trip
    a_r6_sleep_not_off: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_SLEEP && !hot_i) |=> (state_q != PS_OFF));
    // R9: a set trip puts the state in off on the next edge
    a_r9_hot_off: assert property (@(posedge clk) disable iff (rst)
        hot_i |=> (state_q == PS_OFF));
endmodule

// File: rtl/acpi_pwr_seq_rails.sv
module acpi_pwr_seq_rails
    import acpi_pwr_seq_pkg::*;
(
    input  pwr_state_e state_i,
    input  logic       inreg_i,
    input  logic       ss_done_i,
    output rail_ctrl_t ctrl_o
);
    logic sw_ready;

    assign sw_ready = inreg_i & ss_done_i;

    always_comb begin
        ctrl_o = '0;
        case (state_i)
            PS_RUN: begin
                ctrl_o.sw_en   = 1'b1;
                ctrl_o.term_en = sw_ready;
                ctrl_o.lin_en  = sw_ready;
            end
            PS_SLEEP: begin
                ctrl_o.sw_en     = 1'b1;
                ctrl_o.stby_freq = 1'b1;
            end
            default: ctrl_o = '0;
        endcase
    end
endmodule

// File: rtl/acpi_pwr_seq.sv
module acpi_pwr_seq
    import acpi_pwr_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stby_good_i,
    input  logic       main_a_good_i,
    input  logic       main_b_good_i,
    input  logic       sleep_req_i,
    input  logic       temp_over_i,
    input  logic       temp_under_i,
    input  logic       sw_inreg_i,
    input  logic       sw_ss_done_i,
    output logic [1:0] state_o,
    output logic       sw_en_o,
    output logic       stby_freq_o,
    output logic       term_en_o,
    output logic       lin_en_o
);
    supply_flags_t raw_flags;
    supply_flags_t sync_flags;
    logic          hot;
    pwr_state_e    state;
    rail_ctrl_t    ctrl;

    assign raw_flags = '{stby_good:   stby_good_i,
                         main_a_good: main_a_good_i,
                         main_b_good: main_b_good_i,
                         sleep_req:   sleep_req_i};

    acpi_pwr_seq_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_flags),
        .q_o (sync_flags)
    );

    acpi_pwr_seq_thermal u_thermal (
        .clk     (clk),
        .rst     (rst),
        .over_i  (temp_over_i),
        .under_i (temp_under_i),
        .hot_o   (hot)
    );

    acpi_pwr_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .flags_i (sync_flags),
        .hot_i   (hot),
        .state_o (state)
    );

    acpi_pwr_seq_rails u_rails (
        .state_i   (state),
        .inreg_i   (sw_inreg_i),
        .ss_done_i (sw_ss_done_i),
        .ctrl_o    (ctrl)
    );

    assign state_o     = state;
    assign sw_en_o     = ctrl.sw_en;
    assign stby_freq_o = ctrl.stby_freq;
    assign term_en_o   = ctrl.term_en;
    assign lin_en_o    = ctrl.lin_en;

    // R8: termination needs the switching rail running at its normal frequency
    a_r8_term_needs_sw: assert property (@(posedge clk) disable iff (rst)
        term_en_o |-> (sw_en_o && !stby_freq_o));
    // R8: the linear pair follows the switching rail into regulation
    a_r8_lin_needs_reg: assert property (@(posedge clk) disable iff (rst)
        lin_en_o |-> (sw_inreg_i && sw_ss_done_i));
endmodule

// File: tb/acpi_pwr_seq_tb.sv
module acpi_pwr_seq_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [1:0] C_RUN = 2'b00, C_SLEEP = 2'b01, C_OFF = 2'b10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stby, ma, mb, slp, tover, tunder, inreg, ssd;
    logic [1:0] st;
    logic sw_en, sfreq, term_en, lin_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acpi_pwr_seq u_dut (
        .clk(clk), .rst(rst),
        .stby_good_i(stby), .main_a_good_i(ma), .main_b_good_i(mb),
        .sleep_req_i(slp), .temp_over_i(tover), .temp_under_i(tunder),
        .sw_inreg_i(inreg), .sw_ss_done_i(ssd),
        .state_o(st), .sw_en_o(sw_en), .stby_freq_o(sfreq),
        .term_en_o(term_en), .lin_en_o(lin_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_rails(input string req, input logic [3:0] exp);
        chk(req, {sw_en, sfreq, term_en, lin_en}, exp);
    endtask

    task automatic t_reset;
        {stby, ma, mb, slp, tover, tunder, inreg, ssd} = '0;
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R1 state", st, C_OFF);
        chk_rails("R1 rails", 4'b0000);
    endtask

    task automatic t_standby_gate;
        ma = 1'b1; mb = 1'b1;
        cyc(6);
        chk("R7 stays off", st, C_OFF);
    endtask

    task automatic t_power_up;
        stby = 1'b1;
        cyc(2);
        chk("R2 not before third edge", st, C_OFF);
        cyc(1);
        chk("R2 run", st, C_RUN);
        chk_rails("R8 run no regulation", 4'b1000);
    endtask

    task automatic t_rails;
        inreg = 1'b1; ssd = 1'b0;
        cyc(1);
        chk_rails("R8 soft start pending", 4'b1000);
        ssd = 1'b1;
        cyc(1);
        chk_rails("R8 both ready", 4'b1011);
        inreg = 1'b0;
        cyc(1);
        chk_rails("R8 regulation lost", 4'b1000);
        inreg = 1'b1;
        cyc(1);
    endtask

    task automatic t_sleep_and_wake;
        slp = 1'b1;
        cyc(3);
        chk("R3 sleep", st, C_SLEEP);
        chk_rails("R3 sleep rails", 4'b1100);
        ma = 1'b0; slp = 1'b0;
        cyc(6);
        chk("R4 stays sleep without main", st, C_SLEEP);
        chk("R6 sleep not off", st != C_OFF, 1'b1);
        ma = 1'b1;
        cyc(3);
        chk("R4 wake", st, C_RUN);
        chk_rails("R4 rails back", 4'b1011);
    endtask

    task automatic t_drop_off;
        mb = 1'b0;
        cyc(3);
        chk("R5 off", st, C_OFF);
        chk_rails("R5 rails", 4'b0000);
        slp = 1'b1; mb = 1'b1;
        cyc(6);
        chk("R6 off ignores sleep", st, C_OFF);
        slp = 1'b0;
        cyc(3);
        chk("R2 run again", st, C_RUN);
    endtask

    task automatic t_thermal_run;
        tover = 1'b1;
        cyc(2);
        chk("R9 trip from run", st, C_OFF);
        tunder = 1'b1;
        cyc(4);
        chk("R10 over wins over under", st, C_OFF);
        tover = 1'b0; tunder = 1'b0;
        cyc(5);
        chk("R10 hysteresis holds", st, C_OFF);
        tunder = 1'b1;
        cyc(3);
        chk("R10 resume", st, C_RUN);
        tunder = 1'b0;
    endtask

    task automatic t_thermal_sleep;
        slp = 1'b1;
        cyc(3);
        chk("R3 sleep again", st, C_SLEEP);
        tover = 1'b1;
        cyc(2);
        chk("R9 trip from sleep", st, C_OFF);
        tover = 1'b0; tunder = 1'b1;
        cyc(4);
        chk("R6 cooled off with sleep high", st, C_OFF);
        slp = 1'b0;
        cyc(3);
        chk("R10 resume after sleep drop", st, C_RUN);
        tunder = 1'b0;
    endtask

    task automatic t_race;
        int saw_sleep;
        saw_sleep = 0;
        slp = 1'b1;
        cyc(1);
        tover = 1'b1;
        for (int i = 0; i < 5; i++) begin
            cyc(1);
            if (st == C_SLEEP) saw_sleep++;
        end
        chk("R11 no sleep cycle", saw_sleep, 0);
        chk("R11 off", st, C_OFF);
        tover = 1'b0; tunder = 1'b1; slp = 1'b0;
        cyc(4);
        chk("R10 resume after race", st, C_RUN);
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_standby_gate();
        t_power_up();
        t_rails();
        t_sleep_and_wake();
        t_drop_off();
        t_thermal_run();
        t_thermal_sleep();
        t_race();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule